// File: doc/BRIEF.md
# Full-Duplex Serial Master Controller

This block runs a four-wire synchronous serial link as the clocking side. The host puts a parallel word on `tx_word`, chooses clock idle level, sampling phase and frame length on the `cfg_*` inputs, and pulses `start`. The block then pulls `sel_n` low and toggles `ser_clk`. On each bit it launches one transmit bit on `ser_out` and captures one reply bit from `ser_in`. The two shift registers at the ends of the link therefore swap contents.

Each frame is 8 or 16 bits, sent most significant bit first. The serial clock rate comes from the system clock. Each half period of `ser_clk` lasts `cfg_div + 1` system clocks. After the last clock transition the line rests at its idle level for one more half period. Then `sel_n` rises, the received word appears on `rx_word`, and `done` pulses.

The settings for idle level, phase, frame length and divider are captured when a transfer is accepted. They hold for the whole frame. A new request is accepted only when the block is idle.

Top module: `spi_xfer_master`

## Requirements
- R1: While reset is asserted, `sel_n` is 1, `ser_out` is 0, `busy` and `done` are 0, `rx_word` is 0, and `ser_clk` equals `cfg_cpol`.
- R2: Transmit bits leave on `ser_out` most significant bit first. A 16-bit frame (`cfg_wide`=1) starts at `tx_word[15]`. An 8-bit frame (`cfg_wide`=0) sends `tx_word[7:0]` starting at bit 7.
- R3: The bits taken from `ser_in` on the sampling edges form `rx_word`, with the first sampled bit most significant. In 8-bit frames the word sits in `rx_word[7:0]` and bits 15:8 are 0.
- R4: While idle, `ser_clk` equals `cfg_cpol` (0 means low, 1 means high). During the final half period before `sel_n` rises, `ser_clk` is at the captured idle level.
- R5: With phase 0 (`cfg_cpha`=0), `ser_in` is sampled on the 1st, 3rd, 5th… transition of `ser_clk`. With phase 1, it is sampled on the 2nd, 4th… transition. `ser_out` changes only on the other transitions.
- R6: With phase 0, `ser_out` carries the first data bit from the clock edge at which `sel_n` falls, before any `ser_clk` transition. With phase 1, `ser_out` is 0 until the first transition.
- R7: Between the fall and the rise of `sel_n`, `ser_clk` makes exactly 16 transitions for an 8-bit frame and 32 for a 16-bit frame.
- R8: Successive `ser_clk` transitions are `cfg_div`+1 system clocks apart. `done` rises (2N+1)(`cfg_div`+1) clocks after the accepting edge, where N is the frame length.
- R9: `sel_n` is low only while `busy` is high. It rises in the same cycle as `done`.
- R10: `done` is high for exactly one clock. `rx_word` keeps its value until the next `done`.
- R11: A `start` that arrives while `busy` is high is ignored. The running frame completes unchanged, with one `done`, and no second frame follows.
- R12: Changing `cfg_cpol`, `cfg_cpha`, `cfg_wide` or `cfg_div` during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a transfer (taken only when idle) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on odd transitions, 1: sample on even transitions |
| cfg_wide | input | 1 | 1: 16-bit frame, 0: 8-bit frame |
| cfg_div | input | DIV_W | Half period of the serial clock minus one, in system clocks |
| tx_word | input | DATA_W | Word to transmit |
| ser_in | input | 1 | Serial data from the slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse when `rx_word` is updated |
| rx_word | output | DATA_W | Last received word |
| ser_clk | output | 1 | Serial clock |
| ser_out | output | 1 | Serial data to the slave |
| sel_n | output | 1 | Slave select, active low |

## Verification
A wrong edge index or phase decode would show up within one frame. The bits the slave model collects on its sampling edges would no longer match `tx_word`, and `rx_word` would be shifted or carry a stale bit. An error in the half-period counter shows up one half period into the frame, as an uneven spacing of `ser_clk` transitions and a shifted `done` cycle. A select or done sequencing fault is seen within one frame as a transition count other than 2N while `sel_n` is low, or as `done` staying high longer than one clock.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TRAIL = 2'd2
    } xfer_st_e;

endpackage

// File: rtl/sck_edge_gen.sv
module sck_edge_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } eg_state_t;

    eg_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = run && (s_q.cnt == half_div);
        if (!run || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8: the half-period counter never passes the captured divider
    a_r8_cnt_within_div: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.cnt <= half_div));

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_wide,
    input  logic              load_early,
    input  logic [DATA_W-1:0] load_word,
    input  logic              sample,
    input  logic              launch,
    input  logic              clear,
    input  logic              ser_in,
    output logic              ser_out,
    output logic [DATA_W-1:0] frame_bits
);

    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              wide;
        logic              out;
    } sp_state_t;

    sp_state_t s_d, s_q;

    function automatic logic top_bit(input logic [DATA_W-1:0] w, input logic wd);
        return wd ? w[DATA_W-1] : w[NARROW_W-1];
    endfunction

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.wide = load_wide;
            s_d.sh   = load_wide ? load_word : (load_word & NARROW_MASK);
            s_d.out  = load_early ? top_bit(load_word, load_wide) : 1'b0;
        end else if (clear) begin
            s_d.out = 1'b0;
        end else if (sample) begin
            s_d.sh = {s_q.sh[DATA_W-2:0], ser_in};
        end else if (launch) begin
            s_d.out = top_bit(s_q.sh, s_q.wide);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_out    = s_q.out;
    assign frame_bits = s_q.wide ? s_q.sh : (s_q.sh & NARROW_MASK);

    // R5: data-out does not move on a sampling edge
    a_r5_out_still_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !load && !clear) |=> $stable(ser_out));

    // R5: sample and launch never coincide
    a_r5_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample && launch));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int DIV_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_wide,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              ser_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              ser_clk,
    output logic              ser_out,
    output logic              sel_n
);

    localparam int EDGE_W = $clog2(2 * DATA_W);
    localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * DATA_W - 1);
    localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(2 * NARROW_W - 1);

    typedef struct packed {
        xfer_st_e          st;
        logic              cpol;
        logic              cpha;
        logic              wide;
        logic [DIV_W-1:0]  div;
        logic [EDGE_W-1:0] edge_idx;
        logic              sck;
        logic              sel_n;
        logic              done;
        logic [DATA_W-1:0] rx;
    } mx_state_t;

    mx_state_t s_d, s_q;

    logic              tick;
    logic              run;
    logic              take;
    logic              last_edge;
    logic              do_sample;
    logic              do_launch;
    logic [DATA_W-1:0] frame_bits;

    assign run  = (s_q.st != ST_IDLE);
    assign take = (s_q.st == ST_IDLE) && start;

    sck_edge_gen #(
        .DIV_W (DIV_W)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (s_q.div),
        .tick     (tick)
    );

    always_comb begin
        last_edge = (s_q.edge_idx == (s_q.wide ? LAST_WIDE : LAST_NARROW));
        do_sample = (s_q.st == ST_SHIFT) && tick && (s_q.edge_idx[0] == s_q.cpha);
        do_launch = (s_q.st == ST_SHIFT) && tick && (s_q.edge_idx[0] != s_q.cpha)
                    && !last_edge;
    end

    spi_shift_path #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take),
        .load_wide  (cfg_wide),
        .load_early (!cfg_cpha),
        .load_word  (tx_word),
        .sample     (do_sample),
        .launch     (do_launch),
        .clear      (s_d.done),
        .ser_in     (ser_in),
        .ser_out    (ser_out),
        .frame_bits (frame_bits)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st       = ST_SHIFT;
                    s_d.cpol     = cfg_cpol;
                    s_d.cpha     = cfg_cpha;
                    s_d.wide     = cfg_wide;
                    s_d.div      = cfg_div;
                    s_d.edge_idx = '0;
                    s_d.sck      = cfg_cpol;
                    s_d.sel_n    = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    s_d.sck      = ~s_q.sck;
                    s_d.edge_idx = s_q.edge_idx + 1'b1;
                    if (last_edge) begin
                        s_d.st = ST_TRAIL;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    s_d.st    = ST_IDLE;
                    s_d.sel_n = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.rx    = frame_bits;
                end
            end
            default: begin
                s_d.st    = ST_IDLE;
                s_d.sel_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.sel_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = run;
    assign done    = s_q.done;
    assign rx_word = s_q.rx;
    assign sel_n   = s_q.sel_n;
    assign ser_clk = run ? s_q.sck : cfg_cpol;

    // R9: select is asserted only during a transfer
    a_r9_select_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> busy);

    // R9: select releases together with done
    a_r9_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> done);

    // R10: done lasts one clock
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: clock rests at captured idle level in the trailing half period
    a_r4_idle_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_TRAIL) |-> (ser_clk == s_q.cpol));

    // R12: captured settings stay fixed while busy
    a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(s_q.cpol) && $stable(s_q.cpha)
                                   && $stable(s_q.wide) && $stable(s_q.div)));

endmodule

// File: tb/sim_spi_xfer_master.sv
module sim_spi_xfer_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_cpol = 1'b1;
    logic        cfg_cpha = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic [15:0] tx_word = 16'h0;
    logic        ser_in;
    logic        busy, done, ser_clk, ser_out, sel_n;
    logic [15:0] rx_word;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    // slave model state
    int          ecount = 0;
    logic [15:0] got = '0;
    logic [15:0] slave_word = '0;
    logic        m_cpha = 1'b0;
    int          m_n = 8;

    always #2 clk = ~clk;

    spi_xfer_master u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide),
        .cfg_div(cfg_div), .tx_word(tx_word), .ser_in(ser_in),
        .busy(busy), .done(done), .rx_word(rx_word),
        .ser_clk(ser_clk), .ser_out(ser_out), .sel_n(sel_n)
    );

    function automatic logic slave_bit(input int ec, input logic ph, input int n,
                                       input logic [15:0] w);
        int bi;
        bi = ph ? ((ec == 0) ? 0 : (ec - 1) / 2) : ec / 2;
        if (bi >= n) bi = n - 1;
        return w[n - 1 - bi];
    endfunction

    assign ser_in = sel_n ? 1'b0 : slave_bit(ecount, m_cpha, m_n, slave_word);

    always @(negedge sel_n) begin
        ecount = 0;
        got    = '0;
    end

    always @(ser_clk) begin
        if (sel_n === 1'b0) begin
            if ((ecount % 2) == (m_cpha ? 1 : 0)) got = {got[14:0], ser_out};
            ecount = ecount + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_xfer(input logic pol, input logic ph, input logic wd,
                            input int dv, input logic [15:0] tx,
                            input logic [15:0] slv, input bit disturb);
        int n, lat, last_t, m, dones;
        logic prev_clk;
        logic [15:0] mask;
        n    = wd ? 16 : 8;
        mask = wd ? 16'hFFFF : 16'h00FF;
        m    = (2 * n + 1) * (dv + 1);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = ph; cfg_wide = wd; cfg_div = 8'(dv);
        tx_word = tx; slave_word = slv; m_cpha = ph; m_n = n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk(busy === 1'b1 && sel_n === 1'b0, "R9 select low on accept", sel_n, 0);
        // R6: first bit before any clock transition
        chk(ser_out === (ph ? 1'b0 : tx[n-1]), "R6 first bit", ser_out, ph ? 0 : tx[n-1]);
        prev_clk = ser_clk;
        last_t = 1;
        dones = 0;
        while (done !== 1'b1 && lat < 5000) begin
            if (disturb && lat == 2) begin
                cfg_cpol = ~pol; cfg_cpha = ~ph; cfg_wide = ~wd;
                cfg_div = 8'(dv + 2); tx_word = ~tx; start = 1'b1;
            end
            if (disturb && lat == 5) begin
                start = 1'b0;
                cfg_cpol = pol; cfg_cpha = ph; cfg_wide = wd; cfg_div = 8'(dv);
            end
            @(negedge clk);
            lat++;
            if (ser_clk !== prev_clk && sel_n === 1'b0) begin
                if (lat - last_t != dv + 1)
                    chk(1'b0, "R8 half period", lat - last_t, dv + 1);
                last_t = lat;
                prev_clk = ser_clk;
            end
        end
        dones++;
        chk(lat == m + 1, "R8 done latency", lat, m + 1);
        chk(sel_n === 1'b1 && busy === 1'b0, "R9 release with done", sel_n, 1);
        chk(ser_clk === pol, "R4 idle level at release", ser_clk, pol);
        chk(ecount == 2 * n, "R7 transition count", ecount, 2 * n);
        chk(got === (tx & mask), "R2 msb-first transmit", got, tx & mask);
        chk(rx_word === (slv & mask), "R3 receive word", rx_word, slv & mask);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", done, 0);
        chk(rx_word === (slv & mask), "R10 rx held", rx_word, slv & mask);
        if (disturb) begin
            repeat (3) @(negedge clk);
            chk(busy === 1'b0 && sel_n === 1'b1, "R11 no second frame", busy, 0);
            chk(got === (tx & mask) && dones == 1, "R12 settings unaffected", got, tx & mask);
        end
    endtask

    initial begin
        #800000;
        if (!finished) begin
            fails++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sel_n === 1'b1 && ser_out === 1'b0, "R1 reset select/data", {sel_n, ser_out}, 2);
        chk(busy === 1'b0 && done === 1'b0 && rx_word === 16'h0, "R1 reset status", busy, 0);
        chk(ser_clk === 1'b1, "R1 reset clock idle high", ser_clk, 1);
        cfg_cpol = 1'b0;
        @(negedge clk);
        chk(ser_clk === 1'b0, "R4 idle follows polarity", ser_clk, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 sweep over all modes, both frame lengths and several dividers
        for (int mode = 0; mode < 4; mode++) begin
            for (int wd = 0; wd < 2; wd++) begin
                for (int di = 0; di < 3; di++) begin
                    int dv;
                    logic [15:0] tx, slv;
                    dv  = (di == 0) ? 0 : ((di == 1) ? 1 : 3);
                    tx  = 16'hA53C ^ 16'((mode * 3 + di) * 16'h1111);
                    slv = 16'h5AC3 + 16'((mode * 7 + wd * 5 + di) * 37);
                    run_xfer(mode[1], mode[0], wd[0], dv, tx, slv, 1'b0);
                end
            end
        end
        // R11 and R12: start and settings disturbed mid-transfer
        for (int mode = 0; mode < 4; mode++) begin
            run_xfer(mode[1], mode[0], mode[0] ^ mode[1], 1, 16'hC35A, 16'h96E1, 1'b1);
        end
        // boundary words
        run_xfer(1'b0, 1'b0, 1'b1, 0, 16'hFFFF, 16'h0000, 1'b0);
        run_xfer(1'b1, 1'b1, 1'b1, 2, 16'h0000, 16'hFFFF, 1'b0);
        run_xfer(1'b0, 1'b1, 1'b0, 0, 16'h8001, 16'hFF80, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule